// File: doc/BRIEF.md
# Precise Exception Tracker

This block follows every instruction in a five-stage in-order pipeline and keeps a record of the faults it raises. Each stage reports its own fault strobes while it holds an instruction. The block ORs them into a cumulative status vector that moves down the pipeline one stage per clock, in step with the datapath. When a stage holds an instruction whose vector has any bit set, that stage's write-kill output is raised, so the instruction cannot change architectural state.

No exception is acted on when it is detected. The decision is made only when the instruction moves from MEM into WB. An older instruction therefore always traps before any younger one, even when the younger one faulted first in time. When a trap is taken, the block does several things in the cycle the faulting instruction sits in WB. It raises a one-cycle trap request, which redirects fetch to the handler on the next cycle. It raises a flush command that zeroes every pipeline latch, and it kills writes in all stages. It also captures a 3-bit cause and the restart PCs. When the faulting instruction is in a branch delay slot, those PCs include the PC of the branch ahead of it.

The datapath advances one stage per clock. It supplies the valid bit of each stage, and the PC and delay-slot flag of the instruction in MEM.

Top module: `exc_track`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `trap_o`, `flush_o`, `wr_kill_o`, `cause_o`, `epc_o`, `bpc_o` and `dslot_o` are all zero.
- R2: Bit s of `wr_kill_o` (bit 0 IF, 1 ID, 2 EX, 3 MEM, 4 WB) is high in any cycle where stage s holds a valid instruction that has raised a fault strobe in stage s or in any earlier stage.
- R3: A fault strobe raised while its stage's valid bit is low is ignored: outside a flush cycle it causes no write kill and no trap.
- R4: `trap_o` is high in exactly the cycle a valid faulting instruction occupies WB, which is the cycle after it was in MEM.
- R5: Faults are taken in program order. An older instruction's trap wins over faults already raised by younger instructions, and those younger faults are discarded by the flush.
- R6: `flush_o` is high in the same single cycle as `trap_o`. In that cycle every `wr_kill_o` bit is high. At the following edge, every fault record held for in-flight instructions is cleared.
- R7: `cause_o` is the lowest set code among the instruction's faults. The codes are: 0 IF misaligned, 1 IF protection, 2 IF page fault, 3 illegal opcode, 4 arithmetic, 5 MEM misaligned, 6 MEM protection, 7 MEM page fault. `if_fault_i` and `mem_fault_i` use bit 0 for misaligned, bit 1 for protection and bit 2 for page fault. Faults from an earlier stage therefore win.
- R8: On a trap, `epc_o` is the faulting instruction's PC and `dslot_o` is its delay-slot flag. `bpc_o` is the PC of the last valid instruction that entered WB before it when the flag is set, and zero otherwise.
- R9: `cause_o`, `epc_o`, `bpc_o` and `dslot_o` hold their values in every cycle without a trap.
- R10: `trap_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_vld_i | input | 5 | Valid bit per stage, bit 0 IF to bit 4 WB |
| if_fault_i | input | 3 | Fetch faults: misaligned, protection, page fault |
| id_illegal_i | input | 1 | Illegal opcode found in decode |
| ex_arith_i | input | 1 | Arithmetic fault in execute |
| mem_fault_i | input | 3 | Data access faults: misaligned, protection, page fault |
| mem_pc_i | input | PC_W | PC of the instruction in MEM |
| mem_dslot_i | input | 1 | Instruction in MEM sits in a branch delay slot |
| wr_kill_o | output | 5 | Per-stage write suppression |
| trap_o | output | 1 | Redirect fetch to the handler next cycle |
| flush_o | output | 1 | Zero all pipeline latches at the next edge |
| cause_o | output | 3 | Code of the fault taken |
| epc_o | output | PC_W | PC of the faulting instruction |
| bpc_o | output | PC_W | PC of the branch owning the delay slot, else zero |
| dslot_o | output | 1 | Faulting instruction was in a delay slot |

## Verification
The checker watches several things on every cycle. A flush kills all stages, and traps never come back to back. Each trap is preceded by a killed valid instruction in MEM. The captured trap record stays stable between traps, and no idle stage is killed outside a flush. Some behaviour can only be shown by the bench's instruction stream, which models the pipeline. That includes the choice of the older fault over a younger one in the same cycle, and the cause priority within one instruction. It also includes the branch PC captured for a delay-slot fault across a bubble, and the silent loss of faults from flushed instructions.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG    = 5;
  localparam int S_IF    = 0;
  localparam int S_ID    = 1;
  localparam int S_EX    = 2;
  localparam int S_MEM   = 3;
  localparam int S_WB    = 4;
  // fault group width for the two stages that access memory
  localparam int ACC_W   = 3;
  localparam int IF_LSB  = 0;
  localparam int ID_BIT  = IF_LSB + ACC_W;
  localparam int EX_BIT  = ID_BIT + 1;
  localparam int MEM_LSB = EX_BIT + 1;
  localparam int VEC_W   = MEM_LSB + ACC_W;
  localparam int CAUSE_W = $clog2(VEC_W);
  typedef logic [VEC_W-1:0] exc_vec_t;
endpackage

// File: rtl/exc_stage.sv
// One pipeline slot of fault history: merges this stage's strobes into the
// incoming record, drives the slot's write kill, and registers the record
// for the next stage.
module exc_stage #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             flush_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [VEC_W-1:0] strobe_i,
  output logic             kill_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [VEC_W-1:0] cum;

  assign cum    = vec_i | strobe_i;
  assign kill_o = flush_i | (valid_i & (|cum));

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o <= '0;
    end else if (valid_i && !flush_i) begin
      vec_o <= cum;
    end else begin
      vec_o <= '0;  // bubble or flushed slot carries no faults
    end
  end
endmodule

// File: rtl/exc_prio.sv
// Picks the lowest set fault bit; bit order equals stage order.
module exc_prio #(
  parameter int VEC_W   = 8,
  parameter int CAUSE_W = 3
) (
  input  logic [VEC_W-1:0]   vec_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_i[i]) cause_o = CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/exc_commit.sv
// Trap decision register and the captured restart record.
module exc_commit #(
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic               enter_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               dslot_i,
  output logic               trap_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [PC_W-1:0]    bpc_o,
  output logic               dslot_o
);
  logic [PC_W-1:0] last_pc_q;  // PC of the latest valid instruction to enter WB

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o    <= 1'b0;
      cause_o   <= '0;
      epc_o     <= '0;
      bpc_o     <= '0;
      dslot_o   <= 1'b0;
      last_pc_q <= '0;
    end else begin
      trap_o <= take_i;
      if (enter_i) last_pc_q <= pc_i;
      if (take_i) begin
        cause_o <= cause_i;
        epc_o   <= pc_i;
        dslot_o <= dslot_i;
        bpc_o   <= dslot_i ? last_pc_q : '0;
      end
    end
  end
endmodule

// File: rtl/exc_track.sv
module exc_track
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSTG-1:0]    stage_vld_i,
  input  logic [ACC_W-1:0]   if_fault_i,
  input  logic               id_illegal_i,
  input  logic               ex_arith_i,
  input  logic [ACC_W-1:0]   mem_fault_i,
  input  logic [PC_W-1:0]    mem_pc_i,
  input  logic               mem_dslot_i,
  output logic [NSTG-1:0]    wr_kill_o,
  output logic               trap_o,
  output logic               flush_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [PC_W-1:0]    bpc_o,
  output logic               dslot_o
);
  exc_vec_t strobe [NSTG-1];
  exc_vec_t vec_q  [NSTG];
  exc_vec_t mem_cum;
  logic     flush;
  logic     take;
  logic [CAUSE_W-1:0] cause_d;

  // place each stage's strobes at its own bit positions
  assign strobe[S_IF]  = exc_vec_t'(if_fault_i)   << IF_LSB;
  assign strobe[S_ID]  = exc_vec_t'(id_illegal_i) << ID_BIT;
  assign strobe[S_EX]  = exc_vec_t'(ex_arith_i)   << EX_BIT;
  assign strobe[S_MEM] = exc_vec_t'(mem_fault_i)  << MEM_LSB;
  assign vec_q[S_IF]   = '0;

  generate
    for (genvar s = 0; s < NSTG - 1; s++) begin : g_stg
      exc_stage #(.VEC_W(VEC_W)) u_stg (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (stage_vld_i[s]),
        .flush_i  (flush),
        .vec_i    (vec_q[s]),
        .strobe_i (strobe[s]),
        .kill_o   (wr_kill_o[s]),
        .vec_o    (vec_q[s+1])
      );
    end
  endgenerate

  assign wr_kill_o[S_WB] = flush | (stage_vld_i[S_WB] & (|vec_q[S_WB]));

  // decision at the MEM->WB edge so the registered trap lines up with WB
  assign mem_cum = vec_q[S_MEM] | strobe[S_MEM];
  assign take    = stage_vld_i[S_MEM] & (|mem_cum) & ~flush;

  exc_prio #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_prio (
    .vec_i   (mem_cum),
    .cause_o (cause_d)
  );

  exc_commit #(.PC_W(PC_W), .CAUSE_W(CAUSE_W)) u_commit (
    .clk     (clk),
    .rst     (rst),
    .take_i  (take),
    .enter_i (stage_vld_i[S_MEM] & ~flush),
    .cause_i (cause_d),
    .pc_i    (mem_pc_i),
    .dslot_i (mem_dslot_i),
    .trap_o  (trap_o),
    .cause_o (cause_o),
    .epc_o   (epc_o),
    .bpc_o   (bpc_o),
    .dslot_o (dslot_o)
  );

  assign flush   = trap_o;
  assign flush_o = flush;
endmodule

// File: rtl/exc_track_chk.sv
module exc_track_chk
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NSTG-1:0]    stage_vld_i,
  input logic [NSTG-1:0]    wr_kill_o,
  input logic               trap_o,
  input logic               flush_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [PC_W-1:0]    epc_o,
  input logic [PC_W-1:0]    bpc_o,
  input logic               dslot_o
);
  AST_FLUSH_KILLS_ALL: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (wr_kill_o == {NSTG{1'b1}}));  // R6

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);  // R10

  AST_TRAP_FROM_MEM: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(stage_vld_i[S_MEM] && wr_kill_o[S_MEM]));  // R4

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !trap_o |-> ($stable(cause_o) && $stable(epc_o) && $stable(bpc_o) && $stable(dslot_o)));  // R9

  AST_IDLE_NO_KILL: assert property (@(posedge clk) disable iff (rst)
    !flush_o |-> ((wr_kill_o & ~stage_vld_i) == '0));  // R3
endmodule

bind exc_track exc_track_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stage_vld_i (stage_vld_i),
  .wr_kill_o   (wr_kill_o),
  .trap_o      (trap_o),
  .flush_o     (flush_o),
  .cause_o     (cause_o),
  .epc_o       (epc_o),
  .bpc_o       (bpc_o),
  .dslot_o     (dslot_o)
);

// File: tb/exc_track_tb.sv
module exc_track_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 32;
  localparam int NPROG      = 32;
  localparam int NTRAPS     = 6;

  // entry = {issue, delay_slot, fault_mask}; mask bits use the cause codes
  localparam logic [9:0] PROG [NPROG] = '{
    {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h10}, {2'b10, 8'h00},
    {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h80},
    {2'b10, 8'h10}, {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h00},
    {2'b10, 8'h00}, {2'b10, 8'h21}, {2'b10, 8'h00}, {2'b10, 8'h00},
    {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h00}, {2'b00, 8'h00},
    {2'b11, 8'h08}, {2'b10, 8'h01}, {2'b10, 8'h00}, {2'b10, 8'h00},
    {2'b10, 8'h00}, {2'b10, 8'h40}, {2'b10, 8'h02}, {2'b10, 8'h00},
    {2'b00, 8'h00}, {2'b10, 8'h00}, {2'b10, 8'h04}, {2'b10, 8'h00}
  };
  localparam logic [7:0] UPTO [5] = '{8'h07, 8'h0F, 8'h1F, 8'hFF, 8'hFF};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [4:0]      stage_vld_i = '0;
  logic [2:0]      if_fault_i = '0;
  logic            id_illegal_i = 1'b0;
  logic            ex_arith_i = 1'b0;
  logic [2:0]      mem_fault_i = '0;
  logic [PC_W-1:0] mem_pc_i = '0;
  logic            mem_dslot_i = 1'b0;
  logic [4:0]      wr_kill_o;
  logic            trap_o;
  logic            flush_o;
  logic [2:0]      cause_o;
  logic [PC_W-1:0] epc_o;
  logic [PC_W-1:0] bpc_o;
  logic            dslot_o;

  int n_chk = 0;
  int n_err = 0;
  int occ [5];
  int n_trap = 0;
  logic [PC_W-1:0] last_wb = '0;

  exc_track #(.PC_W(PC_W)) u_dut (
    .clk, .rst, .stage_vld_i, .if_fault_i, .id_illegal_i, .ex_arith_i,
    .mem_fault_i, .mem_pc_i, .mem_dslot_i, .wr_kill_o, .trap_o, .flush_o,
    .cause_o, .epc_o, .bpc_o, .dslot_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mask_of(input int idx);
    return (idx >= 0) ? PROG[idx][7:0] : 8'h00;
  endfunction
  function automatic logic [PC_W-1:0] pc_of(input int idx);
    return PC_W'(32'h1000 + idx * 4);
  endfunction
  function automatic logic [2:0] low_code(input logic [7:0] m);
    logic [2:0] c = '0;
    for (int i = 7; i >= 0; i--) if (m[i]) c = 3'(i);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 5; s++) occ[s] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk({trap_o, flush_o, wr_kill_o, cause_o, dslot_o} == '0 && epc_o == '0 && bpc_o == '0,
        "R1 reset", {trap_o, flush_o, wr_kill_o}, 0);
    rst = 1'b0;
    occ[0] = PROG[0][9] ? 0 : -1;

    for (int cyc = 0; cyc < NPROG + 6; cyc++) begin
      logic       exp_trap;
      logic [4:0] exp_kill;
      logic [7:0] m;
      @(negedge clk);
      for (int s = 0; s < 5; s++) stage_vld_i[s] = (occ[s] >= 0);
      if_fault_i   = mask_of(occ[0])[2:0];
      id_illegal_i = mask_of(occ[1])[3];
      ex_arith_i   = mask_of(occ[2])[4];
      mem_fault_i  = mask_of(occ[3])[7:5];
      mem_pc_i     = (occ[3] >= 0) ? pc_of(occ[3]) : '0;
      mem_dslot_i  = (occ[3] >= 0) ? PROG[occ[3]][8] : 1'b0;
      #2;
      m = mask_of(occ[4]);
      exp_trap = (occ[4] >= 0) && (m != 0);
      for (int s = 0; s < 5; s++)
        exp_kill[s] = exp_trap | ((occ[s] >= 0) && ((mask_of(occ[s]) & UPTO[s]) != 0));
      chk(trap_o == exp_trap && flush_o == exp_trap, "R4/R10 trap timing", {trap_o, flush_o}, {exp_trap, exp_trap});
      chk(wr_kill_o == exp_kill, exp_trap ? "R6 flush kill" : "R2 write kill", wr_kill_o, exp_kill);
      if (exp_trap) begin
        n_trap++;
        chk(cause_o == low_code(m), "R7 cause", cause_o, low_code(m));
        chk(epc_o == pc_of(occ[4]), "R8 epc", epc_o, pc_of(occ[4]));
        chk(dslot_o == PROG[occ[4]][8], "R8 dslot", dslot_o, PROG[occ[4]][8]);
        chk(bpc_o == (PROG[occ[4]][8] ? last_wb : '0), "R8 bpc", bpc_o,
            PROG[occ[4]][8] ? last_wb : '0);
      end
      if (occ[4] >= 0) last_wb = pc_of(occ[4]);
      @(posedge clk);
      if (exp_trap) begin
        for (int s = 1; s < 5; s++) occ[s] = -1;
      end else begin
        for (int s = 4; s > 0; s--) occ[s] = occ[s-1];
      end
      occ[0] = (cyc + 1 < NPROG && PROG[cyc+1][9]) ? cyc + 1 : -1;
    end

    // R5: younger faults in flight are dropped, so only the oldest in each window traps
    chk(n_trap == NTRAPS, "R5 trap count", n_trap, NTRAPS);

    // R3: strobes on empty stages
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      stage_vld_i  = '0;
      if_fault_i   = '1;
      id_illegal_i = 1'b1;
      ex_arith_i   = 1'b1;
      mem_fault_i  = '1;
      mem_pc_i     = 32'hDEAD_0000;
      mem_dslot_i  = 1'b1;
      #2;
      chk(wr_kill_o == '0 && trap_o == 1'b0, "R3 idle strobes", {wr_kill_o, trap_o}, 0);
    end

    // R9: record from the last trap (entry 30) is held
    chk(cause_o == 3'd2 && epc_o == pc_of(30) && dslot_o == 1'b0 && bpc_o == '0,
        "R9 record hold", epc_o, pc_of(30));

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk({trap_o, flush_o, wr_kill_o, cause_o, dslot_o} == '0 && epc_o == '0 && bpc_o == '0,
        "R1 re-reset", epc_o, 0);
    finish_run();
  end
endmodule